// File: doc/BRIEF.md
# Receive Character Queue with Error Status

This block sits between a serial receiver and the register bank of a UART channel. Each character from the receiver is queued with three quality flags: line break, framing error and parity error. The flags move through the queue with their character. The block also produces an 8-bit status word. That word combines the flags with an overrun indication, queue occupancy and two transmitter indications, which the block passes through unchanged.

A mode input picks how the three quality bits of the status word behave. In character mode they describe only the character at the head of the queue, so they change as characters are read out. In block mode they gather the flags of every accepted character until software clears them with an error-reset command. A receiver-reset command returns the whole receive side to its idle state.

Top module: `rx_err_fifo`

## Requirements
- R1: `rd_data_o` shows the oldest stored character. Characters come out in the order they were accepted. When the queue is empty, `rd_data_o` is 0. A read strobe on an empty queue has no effect.
- R2: Status bit 0 is 1 when at least one character is stored. Status bit 1 is 1 when all `DEPTH` entries are occupied.
- R3: With `blk_mode_i` = 0, status bits 7, 6 and 5 are the break, framing and parity flags of the head character. They are 0 when the queue is empty. Reading that character removes its flags.
- R4: With `blk_mode_i` = 1, status bits 7, 6 and 5 are the OR of the break, framing and parity flags of every character accepted since the last clear. Reading characters does not change them.
- R5: A write with the queue full and no read in the same cycle discards the incoming character. The stored entries stay as they were, and status bit 4 (overrun) is set. Overrun stays set until a clear.
- R6: A read and a write in the same cycle on a full queue both take effect. The queue stays full and overrun is not set.
- R7: Command code 4'h4 with `cmd_valid_i` is the error reset. It clears overrun, the block-mode accumulation and the flags of every stored character, and keeps the stored data. A character written in the same cycle keeps its flags and contributes to the accumulation. An overrun in the same cycle leaves overrun set.
- R8: Command code 4'h2 with `cmd_valid_i` is the receiver reset. It empties the queue and clears all error flags, overrun included. A read or write in the same cycle is ignored.
- R9: Status bit 3 follows `tx_empty_i` and status bit 2 follows `tx_rdy_i`.
- R10: With `cmd_valid_i` = 1, any command code other than 4'h2 and 4'h4 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Character from the receiver is valid this cycle |
| wr_data_i | input | 8 | Received character |
| wr_brk_i | input | 1 | Break flag of the received character |
| wr_frm_i | input | 1 | Framing error flag of the received character |
| wr_par_i | input | 1 | Parity error flag of the received character |
| rd_i | input | 1 | Read strobe, removes the head character |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 4 | Command code (4'h4 error reset, 4'h2 receiver reset) |
| blk_mode_i | input | 1 | 0 = character error mode, 1 = block error mode |
| tx_empty_i | input | 1 | Transmitter empty indication |
| tx_rdy_i | input | 1 | Transmitter ready indication |
| rd_data_o | output | 8 | Head character |
| status_o | output | 8 | {brk, frm, par, overrun, tx_empty, tx_rdy, full, not_empty} |

## Verification
The assertions assume that `cmd_i` has meaning only while `cmd_valid_i` is high. They also assume that every input is known and changes only between clock edges. The overrun-hold property further assumes that the status bits are observed only while no command is pending. The stimulus drives every input to a known value on the falling edge and issues commands only as single-cycle strobes. It keeps `blk_mode_i` constant within each phase and changes it only at phase boundaries, so each mode is checked over many reads and writes. The phases change the read and write densities so the queue spends long stretches full and empty. Error-reset, receiver-reset and unused command codes are mixed in at random throughout.

// File: rtl/rx_err_fifo_pkg.sv
package rx_err_fifo_pkg;
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_flags_t;

  localparam logic [3:0] CMD_RX_RST  = 4'h2;
  localparam logic [3:0] CMD_ERR_RST = 4'h4;
endpackage

// File: rtl/rx_err_fifo_ctrl.sv
module rx_err_fifo_ctrl #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic          push_o,
  output logic          pop_o,
  output logic          ovr_evt_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o
);
  logic [CW-1:0] count_q;
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o    = (count_q == CW'(DEPTH));
  assign empty_o   = (count_q == '0);
  assign pop_o     = rd_i && !empty_o && !flush_i;
  // full queue accepts a write only when a read frees a slot this cycle
  assign push_o    = wr_i && (!full_o || pop_o) && !flush_i;
  assign ovr_evt_o = wr_i && full_o && !pop_o && !flush_i;
  assign wr_ptr_o  = wr_ptr_q;
  assign rd_ptr_o  = rd_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else if (flush_i) begin
      count_q  <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_o) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_o)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({push_o, pop_o})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end
endmodule

// File: rtl/rx_err_fifo_store.sv
module rx_err_fifo_store
  import rx_err_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] wr_ptr_i,
  input  logic [7:0]    wr_data_i,
  input  rx_flags_t     wr_flags_i,
  input  logic          flag_clr_i,
  input  logic [AW-1:0] rd_ptr_i,
  output logic [7:0]    head_data_o,
  output rx_flags_t     head_flags_o
);
  logic [7:0] data_q  [DEPTH];
  rx_flags_t  flags_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic sel;
    assign sel = push_i && (wr_ptr_i == AW'(i));

    always_ff @(posedge clk_i) begin
      if (sel) data_q[i] <= wr_data_i;
    end

    // a write into this slot outranks a same-cycle flag clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         flags_q[i] <= '0;
      else if (sel)        flags_q[i] <= wr_flags_i;
      else if (flag_clr_i) flags_q[i] <= '0;
    end
  end

  assign head_data_o  = data_q[rd_ptr_i];
  assign head_flags_o = flags_q[rd_ptr_i];
endmodule

// File: rtl/rx_err_fifo_errs.sv
module rx_err_fifo_errs
  import rx_err_fifo_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  logic      push_i,
  input  rx_flags_t push_flags_i,
  input  logic      ovr_evt_i,
  output rx_flags_t acc_o,
  output logic      ovr_o
);
  rx_flags_t acc_q;
  logic      ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      acc_q <= (clr_i ? rx_flags_t'('0) : acc_q) | (push_i ? push_flags_i : rx_flags_t'('0));
      ovr_q <= (ovr_q && !clr_i) || ovr_evt_i;
    end
  end

  assign acc_o = acc_q;
  assign ovr_o = ovr_q;
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rx_err_fifo_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_valid_i,
  input  logic [7:0] wr_data_i,
  input  logic       wr_brk_i,
  input  logic       wr_frm_i,
  input  logic       wr_par_i,
  input  logic       rd_i,
  input  logic       cmd_valid_i,
  input  logic [3:0] cmd_i,
  input  logic       blk_mode_i,
  input  logic       tx_empty_i,
  input  logic       tx_rdy_i,
  output logic [7:0] rd_data_o,
  output logic [7:0] status_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          rx_rst, err_rst, any_clr;
  logic          push, pop, ovr_evt, full, empty, ovr;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [7:0]    head_data;
  rx_flags_t     wr_flags, head_flags, acc, shown;

  assign rx_rst   = cmd_valid_i && (cmd_i == CMD_RX_RST);
  assign err_rst  = cmd_valid_i && (cmd_i == CMD_ERR_RST);
  assign any_clr  = rx_rst || err_rst;
  assign wr_flags = '{brk: wr_brk_i, frm: wr_frm_i, par: wr_par_i};

  rx_err_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (rx_rst),
    .wr_i      (wr_valid_i),
    .rd_i      (rd_i),
    .push_o    (push),
    .pop_o     (pop),
    .ovr_evt_o (ovr_evt),
    .full_o    (full),
    .empty_o   (empty),
    .wr_ptr_o  (wr_ptr),
    .rd_ptr_o  (rd_ptr)
  );

  rx_err_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push),
    .wr_ptr_i     (wr_ptr),
    .wr_data_i    (wr_data_i),
    .wr_flags_i   (wr_flags),
    .flag_clr_i   (any_clr),
    .rd_ptr_i     (rd_ptr),
    .head_data_o  (head_data),
    .head_flags_o (head_flags)
  );

  rx_err_fifo_errs u_errs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (any_clr),
    .push_i       (push),
    .push_flags_i (wr_flags),
    .ovr_evt_i    (ovr_evt),
    .acc_o        (acc),
    .ovr_o        (ovr)
  );

  always_comb begin
    if (blk_mode_i)  shown = acc;
    else if (empty)  shown = '0;
    else             shown = head_flags;
  end

  assign rd_data_o = empty ? 8'h00 : head_data;
  assign status_o  = {shown, ovr, tx_empty_i, tx_rdy_i, full, !empty};

  logic unused_pop;
  assign unused_pop = pop;
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_valid_i,
  input logic       wr_brk_i,
  input logic       rd_i,
  input logic       cmd_valid_i,
  input logic [3:0] cmd_i,
  input logic       blk_mode_i,
  input logic [7:0] status_o
);
  AST_FULL_IMPLIES_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[1] |-> status_o[0]); // R2

  AST_CHAR_EMPTY_NO_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blk_mode_i && !status_o[0]) |-> (status_o[7:5] == 3'b000)); // R3

  AST_BLK_ACCUM_BREAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_mode_i && wr_valid_i && wr_brk_i && !cmd_valid_i && (!status_o[1] || rd_i))
    |=> (!blk_mode_i || status_o[7])); // R4

  AST_OVERRUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[1] && wr_valid_i && !rd_i && !cmd_valid_i) |=> (status_o[4] && status_o[1])); // R5

  AST_FULL_RW_NO_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[1] && wr_valid_i && rd_i && !cmd_valid_i && !status_o[4]) |=> (status_o[1] && !status_o[4])); // R6

  AST_OVERRUN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[4] && !cmd_valid_i) |=> status_o[4]); // R5

  AST_ERR_RST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == 4'h4 && !wr_valid_i) |=> (!status_o[4] && (!blk_mode_i || status_o[7:5] == 3'b000))); // R7

  AST_RX_RST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == 4'h2) |=> (status_o[1:0] == 2'b00 && status_o[4] == 1'b0 && (!blk_mode_i || status_o[7:5] == 3'b000))); // R8
endmodule

bind rx_err_fifo rx_err_fifo_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_valid_i  (wr_valid_i),
  .wr_brk_i    (wr_brk_i),
  .rd_i        (rd_i),
  .cmd_valid_i (cmd_valid_i),
  .cmd_i       (cmd_i),
  .blk_mode_i  (blk_mode_i),
  .status_o    (status_o)
);

// File: tb/rx_err_fifo_tb.sv
module rx_err_fifo_tb;
  localparam int DEPTH = 8;
  localparam int WDOG_CYC = 100000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_valid_i = 1'b0, wr_brk_i = 1'b0, wr_frm_i = 1'b0, wr_par_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       rd_i = 1'b0, cmd_valid_i = 1'b0, blk_mode_i = 1'b0;
  logic [3:0] cmd_i = '0;
  logic       tx_empty_i = 1'b0, tx_rdy_i = 1'b0;
  logic [7:0] rd_data_o, status_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [10:0] q[$];
  logic [2:0]  acc = '0;
  logic        ovr = 1'b0;
  string       ctx = "";

  always #2 clk = ~clk;

  rx_err_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
    .wr_brk_i(wr_brk_i), .wr_frm_i(wr_frm_i), .wr_par_i(wr_par_i), .rd_i(rd_i),
    .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i), .blk_mode_i(blk_mode_i),
    .tx_empty_i(tx_empty_i), .tx_rdy_i(tx_rdy_i), .rd_data_o(rd_data_o), .status_o(status_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", req, ctx, act, exp, $time);
    end
  endtask

  // model update from the inputs held across the coming edge
  task automatic model_step();
    bit rxr = cmd_valid_i && cmd_i == 4'h2;
    bit err = cmd_valid_i && cmd_i == 4'h4;
    bit full, pop, push, oev;
    ctx = "";
    if (rxr) begin
      ctx = "R8";
      q.delete(); acc = '0; ovr = 1'b0;
      return;
    end
    full = (q.size() == DEPTH);
    pop  = rd_i && q.size() != 0;
    push = wr_valid_i && (!full || pop);
    oev  = wr_valid_i && full && !pop;
    if (full && wr_valid_i && rd_i) ctx = "R6";
    if (cmd_valid_i && !err) ctx = "R10";
    if (err) begin
      ctx = "R7";
      foreach (q[i]) q[i][10:8] = 3'b000;
      acc = '0; ovr = 1'b0;
    end
    if (pop) void'(q.pop_front());
    if (push) begin
      q.push_back({wr_brk_i, wr_frm_i, wr_par_i, wr_data_i});
      acc |= {wr_brk_i, wr_frm_i, wr_par_i};
    end
    if (oev) ovr = 1'b1;
  endtask

  task automatic compare();
    logic [2:0] f;
    logic [7:0] d;
    f = blk_mode_i ? acc : (q.size() != 0 ? q[0][10:8] : 3'b000);
    d = (q.size() != 0) ? q[0][7:0] : 8'h00;
    chk("R1", rd_data_o, d);
    chk("R2", {6'b0, status_o[1:0]}, {6'b0, q.size() == DEPTH, q.size() != 0});
    chk(blk_mode_i ? "R4" : "R3", {5'b0, status_o[7:5]}, {5'b0, f});
    chk("R5", {7'b0, status_o[4]}, {7'b0, ovr});
    chk("R9", {6'b0, status_o[3:2]}, {6'b0, tx_empty_i, tx_rdy_i});
  endtask

  task automatic run_phase(input int n, input bit blk, input int pw, input int pr, input int pc);
    for (int c = 0; c < n; c++) begin
      int r;
      @(negedge clk);
      blk_mode_i = blk;
      wr_valid_i = ($urandom_range(99) < pw);
      wr_data_i  = 8'($urandom);
      r = $urandom_range(7);
      wr_brk_i   = (r == 0);
      wr_frm_i   = (r == 1) || (r == 3);
      wr_par_i   = (r == 2) || (r == 3);
      rd_i       = ($urandom_range(99) < pr);
      tx_empty_i = 1'($urandom);
      tx_rdy_i   = 1'($urandom);
      cmd_valid_i = ($urandom_range(99) < pc);
      r = $urandom_range(9);
      cmd_i = (r < 5) ? 4'h4 : (r < 7) ? 4'h2 : 4'($urandom_range(15));
      model_step();
      @(posedge clk); #1;
      compare();
    end
  endtask

  initial begin
    #1;
    tx_empty_i = 1'b1; tx_rdy_i = 1'b0;
    #1;
    ctx = "reset";
    chk("R2", status_o, 8'b0000_1000);  // R9 bit 3 follows tx_empty_i
    chk("R1", rd_data_o, 8'h00);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    run_phase(400, 0, 85, 15, 2);  // fill, overflow in char mode
    run_phase(400, 0, 30, 70, 2);  // drain, empty reads
    run_phase(400, 0, 95, 95, 1);  // full with simultaneous read/write
    run_phase(400, 1, 80, 20, 2);  // block mode accumulate
    run_phase(400, 1, 40, 60, 4);
    run_phase(400, 1, 95, 95, 1);
    run_phase(600, 0, 60, 50, 12); // dense commands
    run_phase(400, 1, 60, 50, 12);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule